// File: doc/BRIEF.md
# Page Write Commit Sequencer

This block sits behind the serial command decoder of a byte-addressed nonvolatile memory. The decoder hands it a 12-bit start address, then each received data byte. The sequencer holds the bytes in a one-page buffer of 32 entries and changes nothing in the array while the transfer is still open. When the decoder signals the end of the transfer, the buffered bytes are copied into the array. A timed busy window follows, and the decoder uses it to withhold acknowledges so that a host can poll for completion.

The address pointer advances only inside the page: its five low bits count and the seven page bits stay as loaded. A transfer longer than one page therefore wraps and overwrites its own earlier bytes. A per-offset valid mask records which offsets were filled, so bytes of the page that were not sent keep their old contents. If a new command or a repeated start arrives first, the buffer is dropped. When the protect input is high at the end of the transfer, the buffer is also dropped and no busy window follows. The length of the busy window is a parameter counted in clock cycles.

Top module: `eep_page_commit`

## Requirements
- R1: After reset, busy_o is low and mem_we is low.
- R2: A byte accepted on byte_vld goes to offset ptr of the page loaded by addr_load. mem_addr is {page, offset}, where the page is addr_in[11:5] and the offset is addr_in[4:0]. After each accepted byte only the 5-bit offset increments, wrapping from 31 to 0, and the page bits stay unchanged.
- R3: When more than 32 bytes arrive before the stop, the offset wraps, and a later byte replaces an earlier one at the same offset. The array receives only the last value for each offset.
- R4: No array write happens before a stop. A committing stop writes each received offset exactly once, in ascending offset order, one write per clock. The write for offset j happens in the j-th cycle after the stop edge (counting from 0). Offsets that were not received are not written.
- R5: A committing stop (protect low and at least one buffered byte) raises busy_o in the next cycle. busy_o then stays high for exactly WR_CYCLES cycles.
- R6: If wp_i is high when a stop is accepted, no array write happens and busy_o stays low. The buffer is discarded, so a later stop with wp_i low writes nothing.
- R7: abort_i (a repeated start or a new control byte) discards the buffer without writing. A following stop writes nothing and raises no busy.
- R8: While busy_o is high, byte_vld, addr_load, abort_i and stop_i are all ignored. The pointer keeps its value for the next transfer.
- R9: A stop with an empty buffer starts no write and no busy window.
- R10: When several controls arrive in one cycle, they are handled in this priority order: addr_load, then abort_i, then stop_i, then byte_vld. Only the highest-priority control takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load the start address and clear the buffer |
| addr_in | input | 12 | Start address: page in [11:5], offset in [4:0] |
| byte_vld | input | 1 | One received data byte is present |
| byte_in | input | 8 | Received data byte |
| abort_i | input | 1 | Repeated start or new control byte; drop the buffer |
| stop_i | input | 1 | Stop condition strobe |
| wp_i | input | 1 | Write protect; sampled when a stop is accepted |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 12 | Array write address |
| mem_data | output | 8 | Array write data |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
A corrupted pointer shows up on the first commit after the bad state. The write address lands in the wrong page or at a shifted offset, and this is visible in the same cycle as the strobe. A corrupted valid mask shows up as a write strobe that is missing or extra somewhere in the first 32 busy cycles. A bad timer shows up as a busy window of the wrong length, and the mismatch is seen on the cycle where busy_o should have fallen. The bench compares all outputs against a behavioural model on every clock, so any divergence is reported in the cycle it first appears on the pins.

// File: rtl/eep_pw_pkg.sv
package eep_pw_pkg;
   function automatic int unsigned ceil_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/eep_pw_pointer.sv
module eep_pw_pointer #(
   parameter int ADDR_W = 12,
   parameter int OFS_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    step,
   output logic [ADDR_W-OFS_W-1:0] page,
   output logic [OFS_W-1:0]        ofs
);
   localparam int PG_W = ADDR_W - OFS_W;

   logic [PG_W-1:0]  page_q;
   logic [OFS_W-1:0] ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (load) begin
         page_q <= addr[ADDR_W-1:OFS_W];
         ofs_q  <= addr[OFS_W-1:0];
      end else if (step) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign page = page_q;
   assign ofs  = ofs_q;
endmodule

// File: rtl/eep_pw_buffer.sv
module eep_pw_buffer #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int OFS_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [PAGE_BYTES-1:0] mask_q;
   logic [DATA_W-1:0]     lane_w [PAGE_BYTES];

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_ofs == OFS_W'(i))) q <= wr_data;
      end
      assign lane_w[i] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         mask_q <= '0;
      end else if (wr_en) begin
         mask_q[wr_ofs] <= 1'b1;
      end
   end

   assign rd_data   = lane_w[rd_ofs];
   assign rd_valid  = mask_q[rd_ofs];
   assign any_valid = |mask_q;
endmodule

// File: rtl/eep_pw_timer.sv
module eep_pw_timer #(
   parameter int WR_CYCLES = 64,
   parameter int CNT_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST_CNT) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign cnt  = cnt_q;
   assign last = busy_q && (cnt_q == LAST_CNT);
endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int WR_CYCLES  = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              abort_i,
   input  logic              stop_i,
   input  logic              wp_i,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              busy_o
);
   import eep_pw_pkg::*;

   localparam int OFS_W = ceil_log2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFS_W;
   localparam int CNT_W = ceil_log2(WR_CYCLES) + 1;
   localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

   if ((32'd1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (WR_CYCLES < PAGE_BYTES) begin : g_bad_cycles
      $error("WR_CYCLES must cover one write per page offset");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the offset width");
   end

   logic             idle;
   logic             do_load, do_abort, do_stop, do_byte, commit;
   logic             buf_clr, pend_any, scan_valid;
   logic [PG_W-1:0]  page;
   logic [OFS_W-1:0] ofs;
   logic [CNT_W-1:0] tcnt;
   logic             tlast;
   logic [OFS_W-1:0] scan_ofs;
   logic [DATA_W-1:0] scan_data;
   logic             scan_live;

   // priority: load > abort > stop > byte, all gated by idle
   assign idle     = !busy_o;
   assign do_load  = idle && addr_load;
   assign do_abort = idle && !addr_load && abort_i;
   assign do_stop  = idle && !addr_load && !abort_i && stop_i;
   assign do_byte  = idle && !addr_load && !abort_i && !stop_i && byte_vld;
   assign commit   = do_stop && !wp_i && pend_any;
   assign buf_clr  = do_load || do_abort || (do_stop && !commit) || tlast;

   eep_pw_pointer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (do_load),
      .addr (addr_in),
      .step (do_byte),
      .page (page),
      .ofs  (ofs)
   );

   assign scan_ofs = tcnt[OFS_W-1:0];

   eep_pw_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (buf_clr),
      .wr_en    (do_byte),
      .wr_ofs   (ofs),
      .wr_data  (byte_in),
      .rd_ofs   (scan_ofs),
      .rd_data  (scan_data),
      .rd_valid (scan_valid),
      .any_valid(pend_any)
   );

   eep_pw_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(commit),
      .busy (busy_o),
      .cnt  (tcnt),
      .last (tlast)
   );

   assign scan_live = busy_o && (tcnt < SCAN_END);
   assign mem_we    = scan_live && scan_valid;
   assign mem_addr  = mem_we ? {page, scan_ofs} : '0;
   assign mem_data  = mem_we ? scan_data : '0;
endmodule

// File: rtl/eep_pw_chk.sv
module eep_pw_chk #(
   parameter int ADDR_W    = 12,
   parameter int OFS_W     = 5,
   parameter int WR_CYCLES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_load,
   input logic              abort_i,
   input logic              stop_i,
   input logic              wp_i,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy_o,
   input logic              pend_any
);
   int unsigned run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) run_len <= 0;
      else if (busy_o) run_len <= run_len + 1;
      else run_len <= 0;
   end

   p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy_o);

   p_wp_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !addr_load && !abort_i && stop_i && wp_i) |=> !busy_o);

   p_abort_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !addr_load && abort_i) |=> !pend_any);

   p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !addr_load && !abort_i && stop_i && !wp_i && pend_any) |=> busy_o);

   p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !addr_load && !abort_i && stop_i && !pend_any) |=> !busy_o);

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == WR_CYCLES));

   p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])));

   p_ofs_rising_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr[OFS_W-1:0] > $past(mem_addr[OFS_W-1:0])));
endmodule

bind eep_page_commit eep_pw_chk #(
   .ADDR_W   (ADDR_W),
   .OFS_W    (OFS_W),
   .WR_CYCLES(WR_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_load(addr_load),
   .abort_i  (abort_i),
   .stop_i   (stop_i),
   .wp_i     (wp_i),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .busy_o   (busy_o),
   .pend_any (pend_any)
);

// File: tb/sim_eep_page_commit.sv
module sim_eep_page_commit;
   localparam int WRC = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_load = 1'b0;
   logic [11:0] addr_in = '0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_in = '0;
   logic        abort_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        wp_i = 1'b0;
   logic        mem_we;
   logic [11:0] mem_addr;
   logic [7:0]  mem_data;
   logic        busy_o;

   eep_page_commit #(.WR_CYCLES(WRC)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_vld(byte_vld), .byte_in(byte_in), .abort_i(abort_i),
      .stop_i(stop_i), .wp_i(wp_i), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data), .busy_o(busy_o));

   always #5 clk = ~clk;

   int total = 0;
   int bad = 0;
   int wr_count = 0;
   int busy_cycles = 0;
   logic [7:0] mem_img [4096];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct { int cyc; int addr; int data; } wr_t;
   wr_t  exp_q[$];
   int   tick = 0;
   int   m_left = 0;
   int   m_page = 0;
   int   m_ofs = 0;
   int   m_data [32];
   bit   m_have [32];

   function automatic bit m_any();
      foreach (m_have[j]) if (m_have[j]) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      tick++;
      if (!rst_n) begin
         m_left = 0; m_page = 0; m_ofs = 0;
         foreach (m_have[j]) m_have[j] = 1'b0;
         exp_q.delete();
      end else if (m_left > 0) begin
         m_left--;
      end else if (addr_load) begin
         m_page = int'(addr_in) / 32;
         m_ofs  = int'(addr_in) % 32;
         foreach (m_have[j]) m_have[j] = 1'b0;
      end else if (abort_i) begin
         foreach (m_have[j]) m_have[j] = 1'b0;
      end else if (stop_i) begin
         if (!wp_i && m_any()) begin
            for (int j = 0; j < 32; j++)
               if (m_have[j]) exp_q.push_back('{tick + j, m_page * 32 + j, m_data[j]});
            m_left = WRC;
         end
         foreach (m_have[j]) m_have[j] = 1'b0;
      end else if (byte_vld) begin
         m_data[m_ofs] = int'(byte_in);
         m_have[m_ofs] = 1'b1;
         m_ofs = (m_ofs + 1) % 32;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit ewe;
         ewe = (exp_q.size() > 0) && (exp_q[0].cyc == tick);
         check(mem_we == ewe, "R4 write strobe", int'(mem_we), int'(ewe));
         check(busy_o == (m_left > 0), "R5 busy", int'(busy_o), int'(m_left > 0));
         if (ewe && mem_we) begin
            check(int'(mem_addr) == exp_q[0].addr, "R2 address", int'(mem_addr), exp_q[0].addr);
            check(int'(mem_data) == exp_q[0].data, "R3 data", int'(mem_data), exp_q[0].data);
         end
         if (ewe) void'(exp_q.pop_front());
         if (mem_we) begin
            wr_count++;
            mem_img[mem_addr] = mem_data;
         end
         if (busy_o) busy_cycles++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [11:0] a);
      @(negedge clk); addr_load = 1'b1; addr_in = a;
      @(negedge clk); addr_load = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] b);
      @(negedge clk); byte_vld = 1'b1; byte_in = b;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic do_stop(input logic wp);
      @(negedge clk); stop_i = 1'b1; wp_i = wp;
      @(negedge clk); stop_i = 1'b0; wp_i = 1'b0;
   endtask

   task automatic do_abort();
      @(negedge clk); abort_i = 1'b1;
      @(negedge clk); abort_i = 1'b0;
   endtask

   task automatic wait_idle();
      int g;
      g = 0;
      while (busy_o && g < 1000) begin @(negedge clk); g++; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int w0, b0;
      foreach (mem_img[i]) mem_img[i] = 8'h00;
      idle_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
      check(mem_we == 1'b0, "R1 we after reset", int'(mem_we), 0);

      // single byte write, R4 R5
      w0 = wr_count; b0 = busy_cycles;
      do_load(12'h123);
      do_byte(8'hA5);
      check(wr_count == w0, "R4 nothing before stop", wr_count - w0, 0);
      do_stop(1'b0);
      wait_idle();
      check(mem_img[12'h123] == 8'hA5, "R4 byte committed", int'(mem_img[12'h123]), 'hA5);
      check(wr_count - w0 == 1, "R4 single write count", wr_count - w0, 1);
      check(busy_cycles - b0 == WRC, "R5 busy length", busy_cycles - b0, WRC);

      // wrap within page, R2
      w0 = wr_count;
      do_load(12'h3FC);
      for (int k = 0; k < 6; k++) do_byte(8'h10 + 8'(k));
      do_stop(1'b0);
      wait_idle();
      check(mem_img[12'h3E0] == 8'h14, "R2 wrap to page start", int'(mem_img[12'h3E0]), 'h14);
      check(mem_img[12'h3E1] == 8'h15, "R2 wrap second", int'(mem_img[12'h3E1]), 'h15);
      check(mem_img[12'h400] == 8'h00, "R2 next page untouched", int'(mem_img[12'h400]), 0);
      check(wr_count - w0 == 6, "R4 only received offsets", wr_count - w0, 6);

      // overflow overwrite, R3
      w0 = wr_count;
      do_load(12'h040);
      for (int k = 0; k < 34; k++) do_byte(8'h80 + 8'(k));
      do_stop(1'b0);
      wait_idle();
      check(mem_img[12'h040] == 8'hA0, "R3 offset0 overwritten", int'(mem_img[12'h040]), 'hA0);
      check(mem_img[12'h041] == 8'hA1, "R3 offset1 overwritten", int'(mem_img[12'h041]), 'hA1);
      check(mem_img[12'h042] == 8'h82, "R3 offset2 kept", int'(mem_img[12'h042]), 'h82);
      check(wr_count - w0 == 32, "R3 one write per offset", wr_count - w0, 32);

      // write protect, R6
      w0 = wr_count; b0 = busy_cycles;
      do_load(12'h200);
      do_byte(8'h55); do_byte(8'h66);
      do_stop(1'b1);
      idle_cyc(5);
      check(busy_cycles == b0, "R6 no busy under protect", busy_cycles - b0, 0);
      do_stop(1'b0);
      idle_cyc(5);
      check(wr_count == w0, "R6 buffer discarded", wr_count - w0, 0);
      check(mem_img[12'h200] == 8'h00, "R6 array unchanged", int'(mem_img[12'h200]), 0);

      // abort, R7
      w0 = wr_count; b0 = busy_cycles;
      do_load(12'h300);
      do_byte(8'h77);
      do_abort();
      do_stop(1'b0);
      idle_cyc(5);
      check(wr_count == w0, "R7 abort drops data", wr_count - w0, 0);
      check(busy_cycles == b0, "R7 no busy after abort", busy_cycles - b0, 0);

      // empty stop, R9
      do_load(12'h500);
      do_stop(1'b0);
      idle_cyc(3);
      check(busy_cycles == b0, "R9 empty stop no busy", busy_cycles - b0, 0);

      // ignored while busy, R8
      do_load(12'h600);
      do_byte(8'h01);
      do_stop(1'b0);
      do_load(12'h7E0);
      do_byte(8'hEE);
      do_abort();
      do_stop(1'b0);
      wait_idle();
      w0 = wr_count;
      do_byte(8'h02);
      do_stop(1'b0);
      wait_idle();
      check(mem_img[12'h601] == 8'h02, "R8 pointer kept through busy", int'(mem_img[12'h601]), 'h02);
      check(mem_img[12'h7E0] == 8'h00, "R8 load ignored while busy", int'(mem_img[12'h7E0]), 0);
      check(wr_count - w0 == 1, "R8 old byte not rewritten", wr_count - w0, 1);

      // simultaneous controls, R10
      w0 = wr_count;
      do_load(12'h700);
      @(negedge clk); byte_vld = 1'b1; byte_in = 8'h3C; stop_i = 1'b1;
      @(negedge clk); byte_vld = 1'b0; stop_i = 1'b0;
      idle_cyc(2);
      check(wr_count == w0, "R10 stop beats byte", wr_count - w0, 0);
      do_byte(8'h4D);
      @(negedge clk); abort_i = 1'b1; stop_i = 1'b1;
      @(negedge clk); abort_i = 1'b0; stop_i = 1'b0;
      idle_cyc(2);
      check(wr_count == w0, "R10 abort beats stop", wr_count - w0, 0);

      idle_cyc(3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule